// File: doc/BRIEF.md
# Write-Protect Status Register and Guard

This block keeps the control state that decides whether a serial nonvolatile memory may be altered. It owns the write-enable latch, the write-in-progress flag, a status-lock enable bit and a two-bit protection level. A command decoder hands it one-cycle strobes. The block answers each write request in the same cycle with a single allow flag, and it serves an 8-bit status byte that can be read at any time.

The two protection bits fence off an upper portion of the array: nothing, the top quarter, the top half, or the whole of it. The lock enable bit works together with an active-low write-protect pin. When the bit is set and the pin is held low, every status write is refused. An accepted write starts an internal timer of `WRITE_CYCLES` clocks that stands in for the self-timed programming period. While the timer runs the block ignores all commands, and when it expires the latch clears.

Commands are plain strobes with no back-pressure. A request that is refused is dropped, and the decoder learns this from `wr_allowed` in that same cycle. Status is a level output with no handshake. Only one command strobe is expected per cycle; if several arrive together, the priority rules below settle the outcome.

Top module: `wrprot_status`

## Requirements
- R1: After reset, `status_rd` is 0x00, `busy` is 0 and `wr_allowed` is 0.
- R2: While idle, a WREN strobe sets the latch (status bit 1) and a WRDI strobe clears it. When both arrive in the same cycle, WRDI wins.
- R3: While idle, `status_rd` is {lock enable (bit 7), 0 in bits 6..4, protection level (bits 3..2), latch (bit 1), 0 in bit 0}. An accepted status write loads only bits 7, 3 and 2 of `sr_wdata`.
- R4: No array or status write is allowed while the latch is clear.
- R5: An array write is refused when its address lies in the protected range: level 00 protects nothing, 01 protects the top quarter (two address MSBs both 1), 10 protects the top half (address MSB 1), and 11 protects every address.
- R6: A status write is refused when the lock enable bit is 1 and `wp_n` is low. When the lock enable bit is 0, `wp_n` has no effect.
- R7: An accepted write raises `busy` at the next edge and holds it for exactly `WRITE_CYCLES` cycles. During that time `status_rd` reads 0xFF.
- R8: When the write period ends, the latch is clear.
- R9: While `busy` is high, every strobe is ignored and `wr_allowed` stays 0.
- R10: A refused write leaves the latch unchanged and does not raise `busy`.
- R11: `wr_allowed` is combinational in the cycle of the request strobe. If status-write and array-write strobes coincide, the status write is the one performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all state |
| cmd_wren | input | 1 | Set-latch strobe |
| cmd_wrdi | input | 1 | Clear-latch strobe |
| cmd_wrsr | input | 1 | Status-write request strobe |
| sr_wdata | input | 8 | Byte offered with a status write |
| cmd_wr | input | 1 | Array-write request strobe |
| wr_addr | input | ADDR_W | Target address of an array write |
| wp_n | input | 1 | Write-protect pin, active low |
| status_rd | output | 8 | Status byte |
| wr_allowed | output | 1 | The request in this cycle is accepted |
| busy | output | 1 | Write period running |

## Verification
A stuck or wrongly set latch, protection level or lock bit shows in `status_rd` at the first idle cycle after the command that set it. It also shows in `wr_allowed` in the same cycle as the next request, because the allow decision is combinational. A timer that is off by one shows as a `busy` window of the wrong length, counted in whole cycles, and as a status byte that leaves 0xFF one cycle early or late. A missed latch clear at the end of the write period is visible at the first idle cycle.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;
  localparam int SR_LOCK = 7;
  localparam int SR_LVL_HI = 3;
  localparam int SR_LVL_LO = 2;
  localparam int SR_LATCH = 1;
  localparam int SR_BUSY = 0;

  typedef enum logic [1:0] {
    GUARD_NONE    = 2'b00,
    GUARD_QUARTER = 2'b01,
    GUARD_HALF    = 2'b10,
    GUARD_ALL     = 2'b11
  } guard_e;
endpackage

// File: rtl/wrprot_range.sv
module wrprot_range
  import wrprot_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  guard_e              level,
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit
);
  localparam int TOP = ADDR_W - 1;

  logic top_half, top_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_half    = addr[TOP];
      assign top_quarter = addr[TOP] & addr[TOP-1];
    end else begin : g_narrow
      assign top_half    = addr[TOP];
      assign top_quarter = addr[TOP];
    end
  endgenerate

  always_comb begin
    unique case (level)
      GUARD_NONE:    hit = 1'b0;
      GUARD_QUARTER: hit = top_quarter;
      GUARD_HALF:    hit = top_half;
      default:       hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wrprot_timer.sv
module wrprot_timer #(
  parameter int WRITE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic finish
);
  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      left    <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        left    <= LAST;
      end
    end else if (left == '0) begin
      running <= 1'b0;
    end else begin
      left <= left - 1'b1;
    end
  end

  assign finish = running && (left == '0);
endmodule

// File: rtl/wrprot_regs.sv
module wrprot_regs
  import wrprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       latch_set,
  input  logic       latch_clr,
  input  logic       period_end,
  input  logic       load,
  input  logic [7:0] load_data,
  output logic       latch,
  output logic       lock_en,
  output guard_e     level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch   <= 1'b0;
      lock_en <= 1'b0;
      level   <= GUARD_NONE;
    end else begin
      if (period_end || latch_clr) latch <= 1'b0;
      else if (latch_set)          latch <= 1'b1;
      if (load) begin
        lock_en <= load_data[SR_LOCK];
        level   <= guard_e'(load_data[SR_LVL_HI:SR_LVL_LO]);
      end
    end
  end
endmodule

// File: rtl/wrprot_status.sv
module wrprot_status
  import wrprot_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        sr_wdata,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wp_n,
  output logic [7:0]        status_rd,
  output logic              wr_allowed,
  output logic              busy
);
  logic   latch, lock_en, fenced, period_end;
  logic   idle, sr_go, arr_go;
  guard_e level;

  assign idle   = !busy;
  assign sr_go  = cmd_wrsr && idle && latch && !(lock_en && !wp_n);
  assign arr_go = cmd_wr && !cmd_wrsr && idle && latch && !fenced;
  assign wr_allowed = sr_go || arr_go;

  wrprot_range #(.ADDR_W(ADDR_W)) u_range (
    .level (level),
    .addr  (wr_addr),
    .hit   (fenced)
  );

  wrprot_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wr_allowed),
    .running (busy),
    .finish  (period_end)
  );

  wrprot_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_set  (cmd_wren && idle),
    .latch_clr  (cmd_wrdi && idle),
    .period_end (period_end),
    .load       (sr_go),
    .load_data  (sr_wdata),
    .latch      (latch),
    .lock_en    (lock_en),
    .level      (level)
  );

  always_comb begin
    if (busy) status_rd = 8'hFF;
    else      status_rd = {lock_en, 3'b000, level, latch, 1'b0};
  end
endmodule

// File: rtl/wrprot_checker.sv
module wrprot_checker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wren,
  input logic              cmd_wrdi,
  input logic              cmd_wrsr,
  input logic              cmd_wr,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wp_n,
  input logic [7:0]        status_rd,
  input logic              wr_allowed,
  input logic              busy
);
  assert_idle_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status_rd[6:4] == 3'b000 && !status_rd[0]));

  assert_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allowed |-> status_rd[1]);

  assert_pin_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && !busy && status_rd[7] && !wp_n && !cmd_wr) |-> !wr_allowed);

  assert_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status_rd == 8'hFF);

  assert_starts_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allowed |=> busy);

  assert_latch_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status_rd[1]);

  assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_allowed);

  assert_refusal_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !wr_allowed && !cmd_wren && !cmd_wrdi && !cmd_wrsr)
      |=> (!busy && status_rd[1] == $past(status_rd[1])));
endmodule

bind wrprot_status wrprot_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_wren   (cmd_wren),
  .cmd_wrdi   (cmd_wrdi),
  .cmd_wrsr   (cmd_wrsr),
  .cmd_wr     (cmd_wr),
  .wr_addr    (wr_addr),
  .wp_n       (wp_n),
  .status_rd  (status_rd),
  .wr_allowed (wr_allowed),
  .busy       (busy)
);

// File: tb/sim_wrprot_status.sv
module sim_wrprot_status;
  localparam int AW = 8;
  localparam int NC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_wr = 0, wp_n = 1;
  logic [7:0] sr_wdata = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] status_rd;
  logic wr_allowed, busy;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wrprot_status #(.ADDR_W(AW), .WRITE_CYCLES(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .sr_wdata(sr_wdata), .cmd_wr(cmd_wr),
    .wr_addr(wr_addr), .wp_n(wp_n), .status_rd(status_rd),
    .wr_allowed(wr_allowed), .busy(busy)
  );

  function automatic logic fenced(int a, int lvl);
    case (lvl)
      0: return 1'b0;
      1: return a >= (3 << (AW - 2));
      2: return a >= (1 << (AW - 1));
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] sr_of(logic lock, int lvl, logic lat);
    return {lock, 3'b000, 2'(lvl), lat, 1'b0};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // Called at a falling edge; drives one strobe cycle and samples the allow flag.
  task automatic pulse(logic en, logic dis, logic srw, logic aw,
                       logic [7:0] d, logic [AW-1:0] a, output logic ok);
    cmd_wren = en; cmd_wrdi = dis; cmd_wrsr = srw; cmd_wr = aw;
    sr_wdata = d; wr_addr = a;
    #2 ok = wr_allowed;
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_wr = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (status_rd !== 8'hFF) check("R7 status while busy", status_rd, 8'hFF);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic ok;
    int n;
    repeat (3) @(negedge clk);
    check("R1 status", status_rd, 8'h00);
    check("R1 busy", busy, 0);
    check("R1 allow", wr_allowed, 0);
    rst_n = 1'b1;
    @(negedge clk);

    pulse(0, 0, 0, 1, 8'h00, 0, ok); check("R4 array w/o latch", ok, 0);
    pulse(0, 0, 1, 0, 8'h0C, 0, ok); check("R4 status w/o latch", ok, 0);
    check("R4 status unchanged", status_rd, 8'h00);

    pulse(1, 0, 0, 0, 0, 0, ok); check("R2 set latch", status_rd, 8'h02);
    pulse(0, 1, 0, 0, 0, 0, ok); check("R2 clear latch", status_rd, 8'h00);
    pulse(1, 0, 0, 0, 0, 0, ok);
    pulse(1, 1, 0, 0, 0, 0, ok); check("R2 clear wins", status_rd, 8'h00);

    pulse(1, 0, 0, 0, 0, 0, ok);
    pulse(0, 0, 1, 0, 8'hFF, 0, ok); check("R11 status write allowed", ok, 1);
    wait_done(n); check("R7 period length", n, NC);
    check("R3 only 7,3,2 loaded / R8 latch cleared", status_rd, 8'h8C);

    pulse(1, 0, 0, 0, 0, 0, ok);
    wp_n = 0;
    pulse(0, 0, 1, 0, 8'h00, 0, ok); check("R6 locked by pin", ok, 0);
    check("R10 latch kept after lock refusal", status_rd, 8'h8E);
    check("R10 no period", busy, 0);
    wp_n = 1;
    pulse(0, 0, 1, 0, 8'h70, 0, ok); check("R6 pin high unlocks", ok, 1);
    wait_done(n); check("R3 bits 6..4 ignored", status_rd, 8'h00);
    wp_n = 0;
    pulse(1, 0, 0, 0, 0, 0, ok);
    pulse(0, 0, 1, 0, 8'h04, 0, ok); check("R6 pin ignored when unlocked", ok, 1);
    wait_done(n); check("R6 level loaded", status_rd, 8'h04);
    wp_n = 1;

    pulse(1, 0, 0, 0, 0, 0, ok);
    pulse(0, 0, 1, 0, 8'h08, 0, ok); check("R9 setup", ok, 1);
    pulse(1, 0, 0, 0, 0, 0, ok);
    pulse(0, 0, 1, 0, 8'h0C, 0, ok); check("R9 status write while busy", ok, 0);
    pulse(0, 0, 0, 1, 8'h00, 0, ok); check("R9 array write while busy", ok, 0);
    wait_done(n); check("R9 period unaffected", n + 3, NC);
    check("R9 strobes had no effect", status_rd, 8'h08);

    pulse(1, 0, 0, 0, 0, 0, ok);
    pulse(0, 0, 1, 0, 8'h00, 0, ok); wait_done(n);
    pulse(1, 0, 0, 0, 0, 0, ok);
    pulse(0, 0, 1, 1, 8'h04, 0, ok); check("R11 coincident allow", ok, 1);
    wait_done(n); check("R11 status write chosen", status_rd, 8'h04);

    for (int lvl = 0; lvl < 4; lvl++) begin
      pulse(1, 0, 0, 0, 0, 0, ok);
      pulse(0, 0, 1, 0, 8'(lvl << 2), 0, ok); wait_done(n);
      for (int a = 0; a < (1 << AW); a++) begin
        pulse(1, 0, 0, 0, 0, 0, ok);
        pulse(0, 0, 0, 1, 0, AW'(a), ok);
        check("R5 range decision", ok, !fenced(a, lvl));
        if (ok) begin
          wait_done(n);
          check("R7 array period", n, NC);
          check("R8 latch after array write", status_rd, sr_of(0, lvl, 0));
        end else begin
          check("R10 latch kept after range refusal", status_rd, sr_of(0, lvl, 1));
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule